// File: doc/BRIEF.md
# Shared-Timebase Edge-Placed PWM Group

This block produces a group of PWM outputs that all run from one common up-counting timebase. None of the output channels has a counter of its own. The timebase counts ticks from 1 up to a programmed period and then returns to 1. On the last tick of each period it raises a one-tick boundary strobe. Every channel receives the broadcast count and compares it against two edges of its own. The leading edge is set by a phase-shift value in ticks. The trailing edge is set by the phase shift plus a duty width in ticks.

Period, duty, phase and polarity are staged settings. Each one is copied into the working registers only on the boundary strobe, so a new value always starts on a clean period. A change of period therefore moves every channel at the same moment. Counting advances only on cycles where the tick enable is high, which lets a divided clock enable set the tick rate.

A pulse whose trailing edge reaches or passes the period stays active until the counter wraps. Each channel can invert its output so that its idle level is high.

Top module: `tbpwm_group`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the timebase count reads 1, the boundary strobe is low and every PWM output is 0.
- R2: The count changes only in cycles with `tick_en_i` high. It then rises by one, or returns to 1 when it has reached the working period.
- R3: `tb_wrap_o` is high exactly in the cycles where `tick_en_i` is high and the count equals the working period.
- R4: `period_i` is copied into the working period only at a boundary strobe. A `period_i` value below 2 is used as 2.
- R5: A channel is active for a count c when phase < c and c <= phase + duty, with the sum formed one bit wider than the count. The PWM output shows the active state for the count of the previous clock cycle, so it follows the count by one clock.
- R6: If phase + duty is equal to or greater than the period, the pulse stays active up to and including the last count of the period. A duty of 0, or a phase equal to or above the period, keeps the channel inactive for the whole period.
- R7: Changes to a channel's duty, phase and polarity inputs have no effect on its output until the next boundary strobe.
- R8: A channel's polarity bit is 0 for active-high and 1 for active-low. When it is 1, the output is the inverse of the active state.
- R9: All channels compare against the same count, so a period change moves every channel at the same boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_en_i | input | 1 | Timebase tick enable |
| period_i | input | CNT_W | Staged timebase period in ticks |
| duty_i | input | NUM_CH*CNT_W | Staged duty widths, channel k at bits [k*CNT_W +: CNT_W] |
| phase_i | input | NUM_CH*CNT_W | Staged phase shifts, channel k at bits [k*CNT_W +: CNT_W] |
| pol_i | input | NUM_CH | Staged polarity, 1 = active-low |
| pwm_o | output | NUM_CH | PWM outputs |
| tb_count_o | output | CNT_W | Broadcast timebase count |
| tb_wrap_o | output | 1 | Boundary strobe |

## Verification
The bench builds the group with an 8-bit count, three channels, a reset period of 6 and a registered output stage. The short periods let every channel go through many wraps in a short run. Three channels are enough to cover, in the same periods, a normal pulse, a pulse that runs past the period end while inverted, and a channel held at zero duty. The 8-bit count makes it cheap to reach a phase beyond the period, a period clamped up to 2, and mid-period changes under a gated tick pattern. All of these are compared against a behavioural model on every clock.

// File: rtl/tbpwm_pkg.sv
package tbpwm_pkg;
   // Shortest period the timebase accepts; smaller requests are raised to it.
   localparam int unsigned MIN_PERIOD = 2;

   typedef enum logic {
      POL_ACT_HIGH = 1'b0,
      POL_ACT_LOW  = 1'b1
   } pol_e;
endpackage

// File: rtl/tbpwm_timebase.sv
module tbpwm_timebase #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned RST_PERIOD = 16
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_en_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] count_o,
   output logic             wrap_o
);
   import tbpwm_pkg::*;

   localparam logic [CNT_W-1:0] MIN_P   = CNT_W'(MIN_PERIOD);
   localparam logic [CNT_W-1:0] RST_P   = CNT_W'(RST_PERIOD);
   localparam logic [CNT_W-1:0] FIRST_C = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] per_q;
   logic [CNT_W-1:0] per_req;
   logic             at_end;

   assign per_req = (period_i < MIN_P) ? MIN_P : period_i;
   assign at_end  = (cnt_q >= per_q);
   assign wrap_o  = tick_en_i & at_end;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         cnt_q <= FIRST_C;
         per_q <= RST_P;
      end else if (tick_en_i) begin
         if (at_end) begin
            cnt_q <= FIRST_C;
            per_q <= per_req;
         end else begin
            cnt_q <= cnt_q + FIRST_C;
         end
      end
   end

   assign count_o = cnt_q;
endmodule

// File: rtl/tbpwm_channel.sv
module tbpwm_channel #(
   parameter int unsigned CNT_W   = 16,
   parameter bit          OUT_REG = 1'b1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [CNT_W-1:0] count_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] duty_i,
   input  logic [CNT_W-1:0] phase_i,
   input  logic             pol_i,
   output logic             pwm_o
);
   import tbpwm_pkg::*;

   logic [CNT_W-1:0] duty_q;
   logic [CNT_W-1:0] phase_q;
   pol_e             pol_q;
   logic [CNT_W:0]   trail_edge;
   logic             in_pulse;
   logic             level;

   // Working settings move only on the shared boundary strobe.
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         duty_q  <= '0;
         phase_q <= '0;
         pol_q   <= POL_ACT_HIGH;
      end else if (wrap_i) begin
         duty_q  <= duty_i;
         phase_q <= phase_i;
         pol_q   <= pol_e'(pol_i);
      end
   end

   assign trail_edge = {1'b0, phase_q} + {1'b0, duty_q};
   assign in_pulse   = (count_i > phase_q) && ({1'b0, count_i} <= trail_edge);
   assign level      = in_pulse ^ (pol_q == POL_ACT_LOW);

   generate
      if (OUT_REG) begin : g_reg_out
         logic pwm_q;
         always_ff @(posedge clk_i) begin
            if (!rst_ni) pwm_q <= 1'b0;
            else         pwm_q <= level;
         end
         assign pwm_o = pwm_q;
      end else begin : g_comb_out
         assign pwm_o = level;
      end
   endgenerate
endmodule

// File: rtl/tbpwm_group.sv
module tbpwm_group #(
   parameter int unsigned CNT_W      = 16,
   parameter int unsigned NUM_CH     = 4,
   parameter int unsigned RST_PERIOD = 16,
   parameter bit          OUT_REG    = 1'b1
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    tick_en_i,
   input  logic [CNT_W-1:0]        period_i,
   input  logic [NUM_CH*CNT_W-1:0] duty_i,
   input  logic [NUM_CH*CNT_W-1:0] phase_i,
   input  logic [NUM_CH-1:0]       pol_i,
   output logic [NUM_CH-1:0]       pwm_o,
   output logic [CNT_W-1:0]        tb_count_o,
   output logic                    tb_wrap_o
);
   localparam longint unsigned CNT_MAX = (64'd1 << CNT_W) - 64'd1;

   initial begin
      if (CNT_W < 2 || CNT_W > 32)
         $error("tbpwm_group: CNT_W must lie in 2..32");
      if (NUM_CH < 1)
         $error("tbpwm_group: NUM_CH must be at least 1");
      if (RST_PERIOD < tbpwm_pkg::MIN_PERIOD || longint'(RST_PERIOD) > CNT_MAX)
         $error("tbpwm_group: RST_PERIOD out of range");
   end

   logic [CNT_W-1:0] count;
   logic             wrap;

   tbpwm_timebase #(
      .CNT_W      (CNT_W),
      .RST_PERIOD (RST_PERIOD)
   ) u_timebase (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .tick_en_i (tick_en_i),
      .period_i  (period_i),
      .count_o   (count),
      .wrap_o    (wrap)
   );

   generate
      for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
         tbpwm_channel #(
            .CNT_W   (CNT_W),
            .OUT_REG (OUT_REG)
         ) u_ch (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .count_i (count),
            .wrap_i  (wrap),
            .duty_i  (duty_i[k*CNT_W +: CNT_W]),
            .phase_i (phase_i[k*CNT_W +: CNT_W]),
            .pol_i   (pol_i[k]),
            .pwm_o   (pwm_o[k])
         );
      end
   endgenerate

   assign tb_count_o = count;
   assign tb_wrap_o  = wrap;
endmodule

// File: rtl/tbpwm_chk.sv
module tbpwm_chk #(
   parameter int unsigned CNT_W  = 16,
   parameter int unsigned NUM_CH = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick,
   input logic [CNT_W-1:0]  count,
   input logic              wrap,
   input logic [NUM_CH-1:0] pwm
);
   assert_hold_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> $stable(count));

   assert_step_up_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && !wrap) |=> (count == CNT_W'($past(count) + 1'b1)));

   assert_reload_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |=> (count == CNT_W'(1)));

   assert_wrap_needs_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wrap |-> tick);

   assert_count_nonzero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      count != '0);

   assert_pwm_known_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$isunknown(pwm));
endmodule

bind tbpwm_group tbpwm_chk #(
   .CNT_W  (CNT_W),
   .NUM_CH (NUM_CH)
) u_tbpwm_chk (
   .clk   (clk_i),
   .rst_n (rst_ni),
   .tick  (tick_en_i),
   .count (tb_count_o),
   .wrap  (tb_wrap_o),
   .pwm   (pwm_o)
);

// File: tb/tb_tbpwm_group.sv
module tb_tbpwm_group;
   localparam int W  = 8;
   localparam int NC = 3;
   localparam int RP = 6;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0;
   logic [W-1:0]  period = 8'(RP);
   logic [W-1:0]  duty_v  [NC];
   logic [W-1:0]  phase_v [NC];
   logic [NC-1:0] pol = '0;
   logic [NC*W-1:0] duty_flat, phase_flat;
   logic [NC-1:0] pwm;
   logic [W-1:0]  cnt_o;
   logic          wrap_o;

   int checks = 0;
   int fails  = 0;
   bit compare_on = 1'b0;

   // Reference state
   int m_cnt, m_per;
   int m_duty [NC];
   int m_phase[NC];
   int m_pol  [NC];
   int e_pwm  [NC];

   always #10 clk = ~clk;

   always_comb begin
      for (int k = 0; k < NC; k++) begin
         duty_flat[k*W +: W]  = duty_v[k];
         phase_flat[k*W +: W] = phase_v[k];
      end
   end

   tbpwm_group #(.CNT_W(W), .NUM_CH(NC), .RST_PERIOD(RP), .OUT_REG(1'b1)) dut (
      .clk_i(clk), .rst_ni(rst_n), .tick_en_i(tick), .period_i(period),
      .duty_i(duty_flat), .phase_i(phase_flat), .pol_i(pol),
      .pwm_o(pwm), .tb_count_o(cnt_o), .tb_wrap_o(wrap_o));

   task automatic check(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Behavioural reference, advanced on each rising edge.
   always @(posedge clk) begin
      if (!rst_n) begin
         m_cnt = 1; m_per = RP;
         for (int k = 0; k < NC; k++) begin
            m_duty[k] = 0; m_phase[k] = 0; m_pol[k] = 0; e_pwm[k] = 0;
         end
      end else begin
         bit w;
         for (int k = 0; k < NC; k++) begin
            bit act;
            act = (m_cnt > m_phase[k]) && (m_cnt <= m_phase[k] + m_duty[k]);
            e_pwm[k] = act ? (1 - m_pol[k]) : m_pol[k];
         end
         w = tick && (m_cnt >= m_per);
         if (tick) begin
            if (w) begin
               m_cnt = 1;
               m_per = (int'(period) < 2) ? 2 : int'(period);
               for (int k = 0; k < NC; k++) begin
                  m_duty[k] = int'(duty_v[k]);
                  m_phase[k] = int'(phase_v[k]);
                  m_pol[k] = int'(pol[k]);
               end
            end else begin
               m_cnt = m_cnt + 1;
            end
         end
      end
   end

   always @(negedge clk) begin
      if (compare_on && rst_n) begin
         check("R2 R4 R9 count", int'(cnt_o), m_cnt);
         check("R3 wrap", int'(wrap_o), (tick && m_cnt >= m_per) ? 1 : 0);
         for (int k = 0; k < NC; k++)
            check($sformatf("R5 R6 R7 R8 pwm%0d", k), int'(pwm[k]), e_pwm[k]);
      end
   end

   task automatic run(input int n, input int gate);
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         tick = (gate == 0) ? 1'b1 : ((i % gate) != 0);
      end
   endtask

   initial begin
      for (int k = 0; k < NC; k++) begin duty_v[k] = '0; phase_v[k] = '0; end
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1 count", int'(cnt_o), 1);
      check("R1 wrap", int'(wrap_o), 0);
      check("R1 pwm", int'(pwm), 0);
      rst_n = 1'b1;
      compare_on = 1'b1;
      @(negedge clk);
      check("R1 after release", int'(pwm), 0);

      // Normal pulse, overrun pulse inverted (R6, R8), zero duty
      duty_v[0] = 8'd2;  phase_v[0] = 8'd1;
      duty_v[1] = 8'd10; phase_v[1] = 8'd3; pol[1] = 1'b1;
      duty_v[2] = 8'd0;  phase_v[2] = 8'd0;
      run(30, 0);

      // R7: mid-period change, R4/R9: period change
      @(negedge clk); tick = 1'b1;
      while (cnt_o != 8'd3) @(negedge clk);
      duty_v[0] = 8'd5; pol[0] = 1'b1; period = 8'd9;
      check("R7 no early change", int'(pwm[0]), e_pwm[0]);
      run(40, 0);

      // Gated ticks, phase beyond period (R6)
      phase_v[2] = 8'd20; duty_v[2] = 8'd3;
      phase_v[0] = 8'd0;  duty_v[0] = 8'd9; pol[0] = 1'b0;
      run(60, 3);

      // R4: period below minimum is raised to 2
      period = 8'd0;
      run(12, 0);
      begin
         int mx = 0;
         for (int i = 0; i < 12; i++) begin
            @(negedge clk);
            if (int'(cnt_o) > mx) mx = int'(cnt_o);
         end
         check("R4 clamp max count", mx, 2);
      end
      period = 8'd1;
      run(20, 2);

      // Back to longer period with all active-low
      period = 8'd12; pol = 3'b111;
      duty_v[2] = 8'd4; phase_v[2] = 8'd2;
      run(50, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule